// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Nesting Tracker

This block sits in one processor's interrupt interface, beside the priority arbiter. When the processor claims an interrupt, the block compares the arbiter's best candidate with the priority of the work already in progress. If the candidate wins, the block makes it the running interrupt, remembers which interrupt it preempted, and asks the arbiter to drop the candidate's pending bit. When the processor signals completion, the block restores the interrupt that was preempted, along with that interrupt's priority, read through a lookup port.

Completions do not have to come in stack order. Each interrupt ID keeps a predecessor entry. If a completion names an ID that is not the running one, a small state machine follows the predecessor links from the running ID, one link per clock. When it finds the link that names the completed ID, it splices that ID out of the chain. While this walk is in progress the block reports busy and turns away new requests. After each accepted completion the block sends a one-cycle pulse so the source logic can re-pend a level interrupt whose line is still high.

Top module: `irq_nest_tracker`

## Requirements
- R1: An acknowledge strobe is refused when the candidate ID is 1023, or is any other value at or above NUM_SRC, or when its 8-bit priority, zero-extended to 9 bits, is not strictly below the running priority. On a refusal, one cycle later ack_id reads 1023, no clear-pending pulse is sent, and the running ID and running priority are unchanged.
- R2: An accepted acknowledge shows its effect one cycle after the strobe. ack_id and run_id both equal the candidate ID, run_prio equals the candidate priority, and clr_pend_vld pulses for one cycle with clr_pend_id equal to the candidate ID. The ID that was running is stored as the candidate's predecessor. ack_id keeps its value until the next acknowledge strobe.
- R3: After reset, run_id is 1023 (nothing running), run_prio is 0x100, ack_id is 1023, and busy, clr_pend_vld and relevel_chk are 0. Whenever run_id is 1023, run_prio is 0x100.
- R4: A completion strobe whose ID is at or above NUM_SRC, 1023 included, has no effect: no state change and no relevel_chk pulse.
- R5: A completion strobe while run_id is 1023 has no effect.
- R6: Completing the running ID makes its stored predecessor the running ID one cycle later. The new running priority is the value returned on lkp_prio while lkp_id shows that predecessor, or 0x100 if the predecessor is 1023.
- R7: Completing a valid ID that is not running leaves run_id and run_prio unchanged. If that ID appears in the predecessor chain that starts at the running ID, the link naming it is replaced by its own predecessor, and later completions follow the repaired chain.
- R8: An out-of-order completion holds busy high for k+1 cycles, starting the cycle after the strobe. Here k is the number of links examined: the walk stops at the first link that equals the completed ID, at the first link that equals 1023, or after NUM_SRC links.
- R9: While busy is high, an acknowledge strobe is answered with 1023 and no clear-pending pulse, and a completion strobe is dropped without a relevel_chk pulse.
- R10: When acknowledge and completion strobes arrive in the same idle cycle, the completion is handled and the acknowledge is refused: ack_id reads 1023 and no clear-pending pulse is sent.
- R11: Every accepted completion, in order or out of order, produces a one-cycle relevel_chk pulse one cycle after the strobe, with relevel_id equal to the completed ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_req | input | 1 | Acknowledge strobe, one cycle |
| pend_id | input | 10 | Highest-pending candidate ID from the arbiter |
| pend_prio | input | 8 | Priority of the candidate, lower value is more urgent |
| ack_id | output | 10 | Answer to the most recent acknowledge, 1023 if refused |
| eoi_req | input | 1 | Completion strobe, one cycle |
| eoi_id | input | 10 | ID being completed |
| lkp_id | output | 10 | Predecessor of the running ID, sent to the priority lookup (meaningful while idle) |
| lkp_prio | input | 8 | Priority of lkp_id, returned in the same cycle |
| run_id | output | 10 | Running interrupt ID, 1023 when none |
| run_prio | output | 9 | Running priority, 0x100 when none |
| clr_pend_vld | output | 1 | One-cycle request to clear a pending bit |
| clr_pend_id | output | 10 | ID whose pending bit should be cleared |
| relevel_chk | output | 1 | One-cycle pulse after each accepted completion |
| relevel_id | output | 10 | ID just completed, for the level re-assert check |
| busy | output | 1 | Out-of-order unlink walk in progress |

## Verification
Acknowledge and completion can land in the same cycle. The bench provokes this in two places. First, it drives both strobes in one idle cycle, and expects the completion to take effect while the acknowledge answers 1023 with no clear pulse. Second, it drives both strobes in the middle of an unlink walk, and expects both to be turned away while the running state and the walk's cycle count stay as the model predicts. The random phase also asserts the two strobes together about one time in ten, and each result is compared against a bench-side model of the running ID, running priority and predecessor table.

// File: rtl/nest_pkg.sv
package nest_pkg;
    localparam int ID_W    = 10;
    localparam int PRIO_W  = 8;
    localparam int RPRIO_W = PRIO_W + 1;

    localparam logic [ID_W-1:0]    NONE_ID   = '1;
    localparam logic [RPRIO_W-1:0] IDLE_PRIO = RPRIO_W'(1) << PRIO_W;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_WALK,
        WK_DONE
    } walk_st_e;

    typedef struct packed {
        logic [ID_W-1:0]    run_id;
        logic [RPRIO_W-1:0] run_prio;
        logic [ID_W-1:0]    ack_id;
        logic               clr_vld;
        logic [ID_W-1:0]    clr_id;
        logic               rel_vld;
        logic [ID_W-1:0]    rel_id;
    } track_state_t;
endpackage

// File: rtl/nest_pred_table.sv
module nest_pred_table
    import nest_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ID_W-1:0] wr_idx,
    input  logic [ID_W-1:0] wr_val,
    input  logic [ID_W-1:0] rd_a_idx,
    output logic [ID_W-1:0] rd_a_val,
    input  logic [ID_W-1:0] rd_b_idx,
    output logic [ID_W-1:0] rd_b_val
);
    localparam int IW    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int DEPTH = 1 << IW;
    localparam logic [ID_W-1:0] LIM = ID_W'(NUM_SRC);

    logic [ID_W-1:0] link_q [DEPTH];

    // One register per implemented ID; spare slots read as no-predecessor.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        if (g < NUM_SRC) begin : g_live
            logic [ID_W-1:0] slot_d;
            always_comb begin
                slot_d = link_q[g];
                if (wr_en && (wr_idx == ID_W'(g))) begin
                    slot_d = wr_val;
                end
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) link_q[g] <= NONE_ID;
                else        link_q[g] <= slot_d;
            end
        end else begin : g_spare
            assign link_q[g] = NONE_ID;
        end
    end

    assign rd_a_val = (rd_a_idx < LIM) ? link_q[rd_a_idx[IW-1:0]] : NONE_ID;
    assign rd_b_val = (rd_b_idx < LIM) ? link_q[rd_b_idx[IW-1:0]] : NONE_ID;
endmodule

// File: rtl/nest_walker.sv
module nest_walker
    import nest_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [ID_W-1:0] start_cur,
    input  logic [ID_W-1:0] start_tgt,
    input  logic [ID_W-1:0] start_tgt_pred,
    output logic [ID_W-1:0] cur_idx,
    input  logic [ID_W-1:0] link_val,
    output logic            wr_en,
    output logic [ID_W-1:0] wr_val,
    output logic            busy
);
    localparam int SW = $clog2(NUM_SRC + 1);
    localparam logic [SW-1:0] LAST_STEP = SW'(NUM_SRC - 1);

    typedef struct packed {
        walk_st_e        st;
        logic [ID_W-1:0] cur;
        logic [ID_W-1:0] tgt;
        logic [ID_W-1:0] tgt_pred;
        logic [SW-1:0]   step;
    } walk_state_t;

    walk_state_t wk_d, wk_q;

    always_comb begin
        wk_d   = wk_q;
        wr_en  = 1'b0;
        unique case (wk_q.st)
            WK_IDLE: begin
                if (start) begin
                    wk_d.st       = WK_WALK;
                    wk_d.cur      = start_cur;
                    wk_d.tgt      = start_tgt;
                    wk_d.tgt_pred = start_tgt_pred;
                    wk_d.step     = '0;
                end
            end
            WK_WALK: begin
                if (link_val == NONE_ID) begin
                    wk_d.st = WK_DONE;
                end else if (link_val == wk_q.tgt) begin
                    wr_en   = 1'b1;
                    wk_d.st = WK_DONE;
                end else if (wk_q.step == LAST_STEP) begin
                    wk_d.st = WK_DONE;
                end else begin
                    wk_d.cur  = link_val;
                    wk_d.step = wk_q.step + SW'(1);
                end
            end
            WK_DONE: wk_d.st = WK_IDLE;
            default: wk_d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wk_q <= '{st: WK_IDLE, cur: NONE_ID, tgt: NONE_ID,
                      tgt_pred: NONE_ID, step: '0};
        end else begin
            wk_q <= wk_d;
        end
    end

    assign cur_idx = wk_q.cur;
    assign wr_val  = wk_q.tgt_pred;
    assign busy    = (wk_q.st != WK_IDLE);

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_q.st == WK_WALK) |-> (wk_q.step <= LAST_STEP)); // R8
    AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_q.st == WK_DONE) |=> (wk_q.st == WK_IDLE)); // R8
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_q.st == WK_WALK && !wr_en && link_val != NONE_ID && wk_q.step != LAST_STEP)
            |=> (wk_q.st == WK_WALK)); // R8
endmodule

// File: rtl/irq_nest_tracker.sv
module irq_nest_tracker
    import nest_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ack_req,
    input  logic [ID_W-1:0]      pend_id,
    input  logic [PRIO_W-1:0]    pend_prio,
    output logic [ID_W-1:0]      ack_id,
    input  logic                 eoi_req,
    input  logic [ID_W-1:0]      eoi_id,
    output logic [ID_W-1:0]      lkp_id,
    input  logic [PRIO_W-1:0]    lkp_prio,
    output logic [ID_W-1:0]      run_id,
    output logic [RPRIO_W-1:0]   run_prio,
    output logic                 clr_pend_vld,
    output logic [ID_W-1:0]      clr_pend_id,
    output logic                 relevel_chk,
    output logic [ID_W-1:0]      relevel_id,
    output logic                 busy
);
    localparam logic [ID_W-1:0] LIM = ID_W'(NUM_SRC);

    track_state_t st_d, st_q;

    logic            wk_busy, wk_start, wk_we;
    logic [ID_W-1:0] wk_cur, wk_val;
    logic            ack_take;
    logic            tbl_we;
    logic [ID_W-1:0] tbl_widx, tbl_wval, pred_run, pred_tgt, rd_a_idx;

    // Table ports are shared: the walker owns them while busy.
    assign tbl_we   = wk_busy ? wk_we  : ack_take;
    assign tbl_widx = wk_busy ? wk_cur : pend_id;
    assign tbl_wval = wk_busy ? wk_val : st_q.run_id;
    assign rd_a_idx = wk_busy ? wk_cur : st_q.run_id;

    nest_pred_table #(.NUM_SRC(NUM_SRC)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_idx   (tbl_widx),
        .wr_val   (tbl_wval),
        .rd_a_idx (rd_a_idx),
        .rd_a_val (pred_run),
        .rd_b_idx (eoi_id),
        .rd_b_val (pred_tgt)
    );

    nest_walker #(.NUM_SRC(NUM_SRC)) u_walker (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (wk_start),
        .start_cur      (st_q.run_id),
        .start_tgt      (eoi_id),
        .start_tgt_pred (pred_tgt),
        .cur_idx        (wk_cur),
        .link_val       (pred_run),
        .wr_en          (wk_we),
        .wr_val         (wk_val),
        .busy           (wk_busy)
    );

    assign lkp_id = pred_run;

    always_comb begin
        st_d         = st_q;
        st_d.clr_vld = 1'b0;
        st_d.rel_vld = 1'b0;
        wk_start     = 1'b0;
        ack_take     = 1'b0;

        if (ack_req) begin
            st_d.ack_id = NONE_ID;
        end

        if (!wk_busy && eoi_req) begin
            // Completion wins a shared cycle; any acknowledge stays refused.
            if (eoi_id < LIM && st_q.run_id != NONE_ID) begin
                st_d.rel_vld = 1'b1;
                st_d.rel_id  = eoi_id;
                if (eoi_id == st_q.run_id) begin
                    st_d.run_id   = pred_run;
                    st_d.run_prio = (pred_run == NONE_ID) ? IDLE_PRIO
                                                          : {1'b0, lkp_prio};
                end else begin
                    wk_start = 1'b1;
                end
            end
        end else if (!wk_busy && ack_req) begin
            if (pend_id < LIM && {1'b0, pend_prio} < st_q.run_prio) begin
                ack_take      = 1'b1;
                st_d.ack_id   = pend_id;
                st_d.run_id   = pend_id;
                st_d.run_prio = {1'b0, pend_prio};
                st_d.clr_vld  = 1'b1;
                st_d.clr_id   = pend_id;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run_id: NONE_ID, run_prio: IDLE_PRIO, ack_id: NONE_ID,
                      clr_vld: 1'b0, clr_id: NONE_ID,
                      rel_vld: 1'b0, rel_id: NONE_ID};
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_id       = st_q.ack_id;
    assign run_id       = st_q.run_id;
    assign run_prio     = st_q.run_prio;
    assign clr_pend_vld = st_q.clr_vld;
    assign clr_pend_id  = st_q.clr_id;
    assign relevel_chk  = st_q.rel_vld;
    assign relevel_id   = st_q.rel_id;
    assign busy         = wk_busy;

    AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (run_id == NONE_ID) |-> (run_prio == IDLE_PRIO)); // R3
    AST_CLR_IS_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pend_vld |-> (clr_pend_id == run_id && ack_id == run_id)); // R2
    AST_ACK_DEEPENS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pend_vld |-> (run_prio < $past(run_prio))); // R2
    AST_BAD_EOI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && eoi_id >= LIM) |=> ($stable(run_id) && !relevel_chk)); // R4
    AST_IDLE_EOI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && run_id == NONE_ID) |=> ($stable(run_id) && !relevel_chk)); // R5
    AST_WALK_HOLDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(run_id) && $stable(run_prio))); // R7
    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ack_req) |=> (!clr_pend_vld && ack_id == NONE_ID)); // R9
    AST_BUSY_DROPS_EOI: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eoi_req) |=> !relevel_chk); // R9
    AST_COLLIDE_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && eoi_req) |=> !clr_pend_vld); // R10
endmodule

// File: tb/irq_nest_tracker_bench.sv
`timescale 1ns/1ps
module irq_nest_tracker_bench;
    localparam int N = 64;
    localparam int NONE = 1023;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ack_req = 1'b0;
    logic [9:0] pend_id = '0;
    logic [7:0] pend_prio = '0;
    logic [9:0] ack_id;
    logic       eoi_req = 1'b0;
    logic [9:0] eoi_id = '0;
    logic [9:0] lkp_id;
    logic [7:0] lkp_prio;
    logic [9:0] run_id;
    logic [8:0] run_prio;
    logic       clr_pend_vld;
    logic [9:0] clr_pend_id;
    logic       relevel_chk;
    logic [9:0] relevel_id;
    logic       busy;

    always #2 clk = ~clk;

    function automatic logic [7:0] ref_lkp(input logic [9:0] id);
        logic [9:0] t;
        t = (id * 10'd29 + 10'd7) ^ (id >> 2);
        return t[7:0];
    endfunction

    assign lkp_prio = ref_lkp(lkp_id);

    irq_nest_tracker #(.NUM_SRC(N)) u_irq_nest_tracker (
        .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .pend_id(pend_id),
        .pend_prio(pend_prio), .ack_id(ack_id), .eoi_req(eoi_req),
        .eoi_id(eoi_id), .lkp_id(lkp_id), .lkp_prio(lkp_prio),
        .run_id(run_id), .run_prio(run_prio), .clr_pend_vld(clr_pend_vld),
        .clr_pend_id(clr_pend_id), .relevel_chk(relevel_chk),
        .relevel_id(relevel_id), .busy(busy)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    int m_pred[N];
    int m_run = NONE;
    int m_rprio = 256;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_eq(input string req, input string what,
                             input int act, input int exp);
        check(act == exp, req, what, act, exp);
    endtask

    task automatic model_walk(input int tgt, output int k);
        int cur;
        int nxt;
        cur = m_run;
        k = 0;
        while (1) begin
            k++;
            nxt = m_pred[cur];
            if (nxt == NONE) break;
            if (nxt == tgt) begin
                m_pred[cur] = m_pred[tgt];
                break;
            end
            if (k == N) break;
            cur = nxt;
        end
    endtask

    task automatic do_ack(input int id, input int prio);
        bit ok;
        @(negedge clk);
        ack_req = 1'b1; pend_id = 10'(id); pend_prio = 8'(prio);
        @(negedge clk);
        ack_req = 1'b0;
        ok = (id < N) && (prio < m_rprio);
        if (ok) begin
            m_pred[id] = m_run; m_run = id; m_rprio = prio;
            expect_eq("R2", "ack_id", int'(ack_id), id);
            expect_eq("R2", "clr_pend_vld", int'(clr_pend_vld), 1);
            expect_eq("R2", "clr_pend_id", int'(clr_pend_id), id);
        end else begin
            expect_eq("R1", "ack_id refused", int'(ack_id), NONE);
            expect_eq("R1", "clr_pend_vld refused", int'(clr_pend_vld), 0);
        end
        expect_eq(ok ? "R2" : "R1", "run_id", int'(run_id), m_run);
        expect_eq(ok ? "R2" : "R1", "run_prio", int'(run_prio), m_rprio);
    endtask

    // Called at the negedge right after the completion strobe was sampled.
    task automatic eoi_eval(input int id, input bit inject);
        int k;
        int cnt;
        int nxt;
        if (id >= N || m_run == NONE) begin
            expect_eq(id >= N ? "R4" : "R5", "relevel_chk", int'(relevel_chk), 0);
            expect_eq(id >= N ? "R4" : "R5", "run_id", int'(run_id), m_run);
            expect_eq(id >= N ? "R4" : "R5", "run_prio", int'(run_prio), m_rprio);
            expect_eq(id >= N ? "R4" : "R5", "busy", int'(busy), 0);
            return;
        end
        expect_eq("R11", "relevel_chk", int'(relevel_chk), 1);
        expect_eq("R11", "relevel_id", int'(relevel_id), id);
        if (id == m_run) begin
            nxt = m_pred[m_run];
            m_run = nxt;
            m_rprio = (nxt == NONE) ? 256 : int'(ref_lkp(10'(nxt)));
            expect_eq("R6", "run_id", int'(run_id), m_run);
            expect_eq("R6", "run_prio", int'(run_prio), m_rprio);
            expect_eq("R6", "busy", int'(busy), 0);
        end else begin
            model_walk(id, k);
            cnt = 0;
            while (busy && cnt < 4 * N) begin
                cnt++;
                if (inject && cnt == 1) begin
                    ack_req = 1'b1; pend_id = 10'd3; pend_prio = 8'd0;
                    eoi_req = 1'b1; eoi_id = 10'(m_run);
                end
                if (inject && cnt == 2) begin
                    ack_req = 1'b0; eoi_req = 1'b0;
                    expect_eq("R9", "ack_id while busy", int'(ack_id), NONE);
                    expect_eq("R9", "clr_pend_vld while busy", int'(clr_pend_vld), 0);
                    expect_eq("R9", "relevel_chk while busy", int'(relevel_chk), 0);
                end
                @(negedge clk);
            end
            ack_req = 1'b0; eoi_req = 1'b0;
            expect_eq("R8", "busy cycles", cnt, k + 1);
            expect_eq("R7", "run_id held", int'(run_id), m_run);
            expect_eq("R7", "run_prio held", int'(run_prio), m_rprio);
        end
    endtask

    task automatic do_eoi(input int id, input bit inject);
        @(negedge clk);
        eoi_req = 1'b1; eoi_id = 10'(id);
        @(negedge clk);
        eoi_req = 1'b0;
        eoi_eval(id, inject);
    endtask

    task automatic do_both(input int aid, input int aprio, input int eid);
        @(negedge clk);
        ack_req = 1'b1; pend_id = 10'(aid); pend_prio = 8'(aprio);
        eoi_req = 1'b1; eoi_id = 10'(eid);
        @(negedge clk);
        ack_req = 1'b0; eoi_req = 1'b0;
        expect_eq("R10", "ack_id on collision", int'(ack_id), NONE);
        expect_eq("R10", "clr_pend_vld on collision", int'(clr_pend_vld), 0);
        eoi_eval(eid, 1'b0);
    endtask

    function automatic int pick_eoi();
        int r;
        int cur;
        int d;
        r = int'($urandom % 10);
        if (r == 0) return NONE;
        if (r == 1) return N + int'($urandom % 50);
        if (r == 2 || m_run == NONE) return int'($urandom % N);
        cur = m_run;
        d = int'($urandom % 4);
        for (int i = 0; i < d; i++) begin
            if (m_pred[cur] != NONE) cur = m_pred[cur];
        end
        return cur;
    endfunction

    function automatic int pick_prio();
        if (($urandom % 5) == 0 || m_rprio == 0) return int'($urandom % 256);
        return int'($urandom % m_rprio);
    endfunction

    function automatic int pick_ack_id();
        int r;
        r = int'($urandom % 20);
        if (r == 0) return NONE;
        if (r == 1) return N + int'($urandom % 100);
        return int'($urandom % N);
    endfunction

    initial begin
        int op;
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) m_pred[i] = NONE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_eq("R3", "reset run_id", int'(run_id), NONE);
        expect_eq("R3", "reset run_prio", int'(run_prio), 256);
        expect_eq("R3", "reset ack_id", int'(ack_id), NONE);
        expect_eq("R3", "reset busy", int'(busy), 0);
        expect_eq("R3", "reset clr_pend_vld", int'(clr_pend_vld), 0);
        expect_eq("R3", "reset relevel_chk", int'(relevel_chk), 0);

        do_eoi(NONE, 0);          // R4 spurious ID while idle
        do_eoi(5, 0);             // R5 nothing running
        do_ack(NONE, 10);         // R1 no candidate
        do_ack(70, 10);           // R1 out-of-range candidate
        do_ack(10, 200);          // R2
        do_ack(20, 200);          // R1 equal priority refused
        do_ack(20, 100);
        do_ack(30, 50);
        do_ack(40, 20);           // chain 40>30>20>10
        do_eoi(70, 0);            // R4 with work running
        do_eoi(20, 0);            // R7 splice, k=2
        do_eoi(25, 1);            // R8 absent ID, k=3, R9 injection
        do_both(50, 5, 40);       // R10 collision, in-order completion
        do_eoi(30, 0);            // R6 restores 10
        do_eoi(10, 0);            // R6 back to idle, R3 priority
        expect_eq("R3", "idle run_prio", int'(run_prio), 256);

        for (int i = 0; i < 400; i++) begin
            op = int'($urandom % 10);
            if (op < 5)       do_ack(pick_ack_id(), pick_prio());
            else if (op < 9)  do_eoi(pick_eoi(), 0);
            else              do_both(pick_ack_id(), pick_prio(), pick_eoi());
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule